// File: doc/BRIEF.md
# NOR Flash Command Sequencer

This block sits behind a flash-style bus and turns write cycles into commands for a small storage array. Write cycles arrive as address/data pairs. Most commands must be preceded by a two-cycle unlock pattern. The sequencer recognises these commands:

- a return to array reads;
- an identification read;
- word programming;
- erase of one sector, several sectors or the whole array;
- a fast-program mode, in which each word needs only a two-cycle write.

A mode output tells the read path what a bus read returns: stored words, identification codes or a progress status byte. Program and erase run for a fixed number of cycles, counted by a timer. While an operation runs, the status byte lets software poll for completion. Programming can only clear bits. Erase sets every word of the chosen sectors to all ones.

The unlock addresses, unlock data, command codes, identification codes, busy times and the sector-collection window are all parameters. Only bits 7..0 of write data are compared against unlock and command codes.

The write channel is valid/ready. `wr_ready` falls for the whole of a program or erase, and writes are neither accepted nor remembered during that time. The read request channel is also valid/ready, but `rd_ready` is always high. Each accepted read produces exactly one `rsp_valid` pulse with `rsp_data` one cycle later. The response has no back-pressure. A request or write is only taken while `chip_en` is high.

Top module: `nor_cmd_seq`

## Requirements
- R1: After reset the sequencer is in array-read mode: `rd_mode` is 0, `busy` is 0, both ready signals are 1, and every word reads as 16'hFFFF.
- R2: An unlock cycle (a write of unlock data 1 at unlock address 1, then unlock data 2 at unlock address 2) that does not match returns the sequencer to array-read mode, and the writes that follow do not program.
- R3: The sequence unlock, then the identify code at unlock address 1, puts `rd_mode` at 1. Reads then return the maker code when the word address bit 0 is 0 and the device code when it is 1, in bits 7..0, with bits 15..8 zero.
- R4: The reset code (8'hF0) written in identify mode or fast-program mode returns `rd_mode` to 0 and array reads. Other codes written in identify mode leave it there.
- R5: Normal programming is unlock, then the program code at unlock address 1, then the data at the target address. The stored word becomes old AND data.
- R6: Unlock followed by the bypass code enters fast-program mode. In that mode, a program code at any address followed by the data at the target programs in two writes, and the block stays in fast-program mode afterwards.
- R7: `busy` stays high for exactly PROG_CYC cycles after the data write of a program, and for exactly ERASE_CYC cycles once an erase starts. While busy, `wr_ready` is 0 and `rd_mode` is 2. When busy ends, `rd_mode` leaves 2.
- R8: A read in status mode returns: bit 7 equal to the complement of bit 7 of the data being programmed (0 during erase); bit 6 inverted on each successive status read; all other bits zero.
- R9: The sequence unlock, erase code, unlock, then the sector code at an address in a sector marks that sector. The sector is selected by address bits [AW-1 -: log2(SECTS)]. Each further sector code written within SECT_WIN idle cycles adds a sector. After SECT_WIN idle cycles the erase starts. Marked sectors become all ones; other words are unchanged.
- R10: If the sixth cycle of the erase sequence is the chip code at unlock address 1, every word becomes all ones.
- R11: While `chip_en` is 0, reads produce no response and writes have no effect. An operation already running still completes in the same number of cycles.
- R12: An accepted read gives `rsp_valid` high exactly one cycle later, and `rd_ready` is always 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| chip_en | input | 1 | Device select; bus accesses are ignored when low |
| wr_valid | input | 1 | Write cycle valid |
| wr_ready | output | 1 | Write accepted when high; low while busy |
| wr_addr | input | AW | Write word address |
| wr_data | input | DW | Write data |
| rd_valid | input | 1 | Read request valid |
| rd_ready | output | 1 | Read request ready (always 1) |
| rd_addr | input | AW | Read word address |
| rsp_valid | output | 1 | Read response valid |
| rsp_data | output | DW | Read response data |
| rd_mode | output | 2 | 0 = array, 1 = identification, 2 = status |
| busy | output | 1 | Program or erase in progress |

## Verification
A state register that has drifted shows up first on `rd_mode`. It appears at the edge after the faulty write: for example, identification is entered without the unlock, or status mode persists after the timer ends. A lost sector mark or a wrong program merge shows only when the affected words are read back after `busy` falls. For that reason, every operation is followed by reads of the whole array against a bench model. A wrong busy length is caught by counting the cycles `busy` stays high. A missing toggle is caught by comparing bit 6 of two consecutive status responses.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;
  typedef enum logic [1:0] {RM_ARRAY = 2'd0, RM_ID = 2'd1, RM_STATUS = 2'd2} rd_mode_e;
  typedef enum logic [3:0] {
    S_READ, S_U1, S_U2, S_PROG, S_ASEL, S_BYP, S_BYP_PROG,
    S_ERA0, S_ERA1, S_ERACMD, S_ERAWIN, S_BUSY
  } seq_state_e;
endpackage

// File: rtl/nor_seq_timer.sv
module nor_seq_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] load,
  output logic          busy,
  output logic          done
);
  logic [CW-1:0] cnt_q;
  assign busy = (cnt_q != '0);
  assign done = (cnt_q == CW'(1));
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (start) cnt_q <= load;
    else if (busy)  cnt_q <= cnt_q - CW'(1);
  end
endmodule

// File: rtl/nor_seq_store.sv
module nor_seq_store #(
  parameter int AW    = 6,
  parameter int DW    = 16,
  parameter int SECTS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_prog,
  input  logic             start_erase,
  input  logic [AW-1:0]    op_addr,
  input  logic [DW-1:0]    op_data,
  input  logic [SECTS-1:0] op_mask,
  input  logic             done,
  input  logic [AW-1:0]    rd_addr,
  output logic [DW-1:0]    rd_word,
  output logic             pend_d7
);
  localparam int WORDS = 1 << AW;
  localparam int WPS   = WORDS / SECTS;

  logic             erase_q;
  logic [AW-1:0]    addr_q;
  logic [DW-1:0]    data_q;
  logic [SECTS-1:0] mask_q;
  logic [DW-1:0]    mem [WORDS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      erase_q <= 1'b0;
      addr_q  <= '0;
      data_q  <= '1;
      mask_q  <= '0;
    end else if (start_prog) begin
      erase_q <= 1'b0;
      addr_q  <= op_addr;
      data_q  <= op_data;
    end else if (start_erase) begin
      erase_q <= 1'b1;
      data_q  <= '1;
      mask_q  <= op_mask;
    end
  end

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    localparam int SI = g / WPS;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        mem[g] <= '1;
      else if (done && erase_q && mask_q[SI])
        mem[g] <= '1;
      else if (done && !erase_q && addr_q == AW'(g))
        mem[g] <= mem[g] & data_q;
    end
  end

  assign rd_word = mem[rd_addr];
  assign pend_d7 = data_q[7];
endmodule

// File: rtl/nor_seq_fsm.sv
module nor_seq_fsm
  import nor_seq_pkg::*;
#(
  parameter int            AW        = 6,
  parameter int            DW        = 16,
  parameter int            SECTS     = 4,
  parameter int            SECT_WIN  = 8,
  parameter logic [AW-1:0] UA1       = 6'h15,
  parameter logic [AW-1:0] UA2       = 6'h2A,
  parameter logic [7:0]    UD1       = 8'hAA,
  parameter logic [7:0]    UD2       = 8'h55,
  parameter logic [7:0]    CMD_RESET = 8'hF0,
  parameter logic [7:0]    CMD_ASEL  = 8'h90,
  parameter logic [7:0]    CMD_PROG  = 8'hA0,
  parameter logic [7:0]    CMD_ERASE = 8'h80,
  parameter logic [7:0]    CMD_BYP   = 8'h20,
  parameter logic [7:0]    CMD_CHIP  = 8'h10,
  parameter logic [7:0]    CMD_SECT  = 8'h30
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_fire,
  input  logic [AW-1:0]    wr_addr,
  input  logic [DW-1:0]    wr_data,
  input  logic             done,
  output logic             start_prog,
  output logic             start_erase,
  output logic [SECTS-1:0] erase_mask,
  output rd_mode_e         mode
);
  localparam int SB = $clog2(SECTS);
  localparam int WW = $clog2(SECT_WIN + 1);

  seq_state_e       state_q, nxt;
  logic             ret_byp_q, ret_d;
  logic [SECTS-1:0] mask_q, mask_d;
  logic [WW-1:0]    win_q, win_d;
  logic [7:0]       d8;
  logic             hit1, hit2;
  logic [SECTS-1:0] sect_oh;

  assign d8      = wr_data[7:0];
  assign hit1    = (wr_addr == UA1) && (d8 == UD1);
  assign hit2    = (wr_addr == UA2) && (d8 == UD2);
  assign sect_oh = SECTS'(1) << wr_addr[AW-1 -: SB];

  always_comb begin
    nxt         = state_q;
    ret_d       = ret_byp_q;
    mask_d      = mask_q;
    win_d       = win_q;
    start_prog  = 1'b0;
    start_erase = 1'b0;
    case (state_q)
      S_READ:  if (wr_fire) nxt = hit1 ? S_U1 : S_READ;
      S_U1:    if (wr_fire) nxt = hit2 ? S_U2 : S_READ;
      S_U2: if (wr_fire) begin
        if (wr_addr != UA1)        nxt = S_READ;
        else if (d8 == CMD_PROG)   nxt = S_PROG;
        else if (d8 == CMD_ASEL)   nxt = S_ASEL;
        else if (d8 == CMD_ERASE)  nxt = S_ERA0;
        else if (d8 == CMD_BYP)    nxt = S_BYP;
        else                       nxt = S_READ;
      end
      S_PROG: if (wr_fire) begin
        start_prog = 1'b1; ret_d = 1'b0; nxt = S_BUSY;
      end
      S_ASEL:  if (wr_fire && d8 == CMD_RESET) nxt = S_READ;
      S_BYP: if (wr_fire) begin
        if (d8 == CMD_PROG)       nxt = S_BYP_PROG;
        else if (d8 == CMD_RESET) nxt = S_READ;
      end
      S_BYP_PROG: if (wr_fire) begin
        start_prog = 1'b1; ret_d = 1'b1; nxt = S_BUSY;
      end
      S_ERA0:  if (wr_fire) nxt = hit1 ? S_ERA1 : S_READ;
      S_ERA1:  if (wr_fire) nxt = hit2 ? S_ERACMD : S_READ;
      S_ERACMD: if (wr_fire) begin
        if (wr_addr == UA1 && d8 == CMD_CHIP) begin
          mask_d = '1; start_erase = 1'b1; ret_d = 1'b0; nxt = S_BUSY;
        end else if (d8 == CMD_SECT) begin
          mask_d = sect_oh; win_d = '0; nxt = S_ERAWIN;
        end else nxt = S_READ;
      end
      S_ERAWIN: begin
        if (wr_fire) begin
          if (d8 == CMD_SECT) begin mask_d = mask_q | sect_oh; win_d = '0; end
          else nxt = S_READ;
        end else if (win_q == WW'(SECT_WIN - 1)) begin
          start_erase = 1'b1; ret_d = 1'b0; nxt = S_BUSY;
        end else win_d = win_q + WW'(1);
      end
      S_BUSY:  if (done) nxt = ret_byp_q ? S_BYP : S_READ;
      default: nxt = S_READ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= S_READ;
      ret_byp_q <= 1'b0;
      mask_q    <= '0;
      win_q     <= '0;
    end else begin
      state_q   <= nxt;
      ret_byp_q <= ret_d;
      mask_q    <= mask_d;
      win_q     <= win_d;
    end
  end

  assign erase_mask = mask_d;
  assign mode = (state_q == S_BUSY) ? RM_STATUS :
                (state_q == S_ASEL) ? RM_ID : RM_ARRAY;
endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
  import nor_seq_pkg::*;
#(
  parameter int            AW        = 6,
  parameter int            DW        = 16,
  parameter int            SECTS     = 4,
  parameter int            SECT_WIN  = 8,
  parameter int            PROG_CYC  = 6,
  parameter int            ERASE_CYC = 20,
  parameter logic [AW-1:0] UA1       = 6'h15,
  parameter logic [AW-1:0] UA2       = 6'h2A,
  parameter logic [7:0]    UD1       = 8'hAA,
  parameter logic [7:0]    UD2       = 8'h55,
  parameter logic [7:0]    CMD_RESET = 8'hF0,
  parameter logic [7:0]    CMD_ASEL  = 8'h90,
  parameter logic [7:0]    CMD_PROG  = 8'hA0,
  parameter logic [7:0]    CMD_ERASE = 8'h80,
  parameter logic [7:0]    CMD_BYP   = 8'h20,
  parameter logic [7:0]    CMD_CHIP  = 8'h10,
  parameter logic [7:0]    CMD_SECT  = 8'h30,
  parameter logic [7:0]    MFR_ID    = 8'h37,
  parameter logic [7:0]    DEV_ID    = 8'hC4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          chip_en,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_valid,
  output logic          rd_ready,
  input  logic [AW-1:0] rd_addr,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data,
  output logic [1:0]    rd_mode,
  output logic          busy
);
  localparam int MAXC = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  logic             wr_fire, rd_fire, done, start_prog, start_erase, pend_d7, tog_q;
  logic [SECTS-1:0] erase_mask;
  logic [DW-1:0]    rd_word;
  rd_mode_e         mode;

  assign wr_ready = !busy;
  assign rd_ready = 1'b1;
  assign wr_fire  = wr_valid && wr_ready && chip_en;
  assign rd_fire  = rd_valid && chip_en;
  assign rd_mode  = mode;

  nor_seq_fsm #(
    .AW(AW), .DW(DW), .SECTS(SECTS), .SECT_WIN(SECT_WIN),
    .UA1(UA1), .UA2(UA2), .UD1(UD1), .UD2(UD2),
    .CMD_RESET(CMD_RESET), .CMD_ASEL(CMD_ASEL), .CMD_PROG(CMD_PROG),
    .CMD_ERASE(CMD_ERASE), .CMD_BYP(CMD_BYP), .CMD_CHIP(CMD_CHIP), .CMD_SECT(CMD_SECT)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .wr_fire(wr_fire), .wr_addr(wr_addr), .wr_data(wr_data),
    .done(done), .start_prog(start_prog), .start_erase(start_erase),
    .erase_mask(erase_mask), .mode(mode)
  );

  nor_seq_timer #(.CW(CW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .start(start_prog || start_erase),
    .load(start_prog ? CW'(PROG_CYC) : CW'(ERASE_CYC)), .busy(busy), .done(done)
  );

  nor_seq_store #(.AW(AW), .DW(DW), .SECTS(SECTS)) u_store (
    .clk(clk), .rst_n(rst_n), .start_prog(start_prog), .start_erase(start_erase),
    .op_addr(wr_addr), .op_data(wr_data), .op_mask(erase_mask), .done(done),
    .rd_addr(rd_addr), .rd_word(rd_word), .pend_d7(pend_d7)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      tog_q     <= 1'b0;
    end else begin
      rsp_valid <= rd_fire;
      if (rd_fire) begin
        case (mode)
          RM_ID:     rsp_data <= DW'(rd_addr[0] ? DEV_ID : MFR_ID);
          RM_STATUS: rsp_data <= DW'({~pend_d7, tog_q, 6'b0});
          default:   rsp_data <= rd_word;
        endcase
        if (mode == RM_STATUS) tog_q <= ~tog_q;
      end
    end
  end
endmodule

// File: rtl/nor_seq_chk.sv
module nor_seq_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          chip_en,
  input logic          rd_valid,
  input logic          rd_ready,
  input logic          wr_ready,
  input logic          busy,
  input logic [1:0]    rd_mode,
  input logic          rsp_valid,
  input logic [DW-1:0] rsp_data
);
  AST_BUSY_BLOCKS_WR: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !wr_ready);  // R7
  AST_BUSY_STATUS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> rd_mode == 2'd2);  // R7
  AST_END_LEAVES_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> rd_mode != 2'd2);  // R7
  AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_ready && chip_en) |=> rsp_valid);  // R12
  AST_DESEL_NO_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_valid && chip_en) |=> !rsp_valid);  // R11
  AST_ID_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && chip_en && rd_mode == 2'd1) |=> rsp_data[DW-1:8] == '0);  // R3
endmodule

bind nor_cmd_seq nor_seq_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .rd_valid(rd_valid), .rd_ready(rd_ready),
  .wr_ready(wr_ready), .busy(busy), .rd_mode(rd_mode), .rsp_valid(rsp_valid), .rsp_data(rsp_data)
);

// File: tb/sim_nor_cmd_seq.sv
`timescale 1ns/1ps
module sim_nor_cmd_seq;
  localparam int AW = 6, DW = 16, WORDS = 64, PROG_CYC = 6, ERASE_CYC = 20;
  localparam logic [5:0] UA1 = 6'h15, UA2 = 6'h2A;

  logic clk = 0, rst_n = 0, chip_en = 1;
  logic wr_valid = 0, rd_valid = 0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic wr_ready, rd_ready, rsp_valid, busy;
  logic [DW-1:0] rsp_data;
  logic [1:0] rd_mode;
  logic [DW-1:0] mdl [WORDS];
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  nor_cmd_seq u0 (
    .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_addr(rd_addr), .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rd_mode(rd_mode), .busy(busy)
  );

  function automatic logic [DW-1:0] prog_val(logic [DW-1:0] old, logic [DW-1:0] d);
    return old & d;
  endfunction

  function automatic logic [DW-1:0] status_val(logic [DW-1:0] d, logic tog);
    return {8'h00, ~d[7], tog, 6'b0};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk); wr_valid = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_valid = 0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d, output logic v);
    @(negedge clk); rd_valid = 1; rd_addr = a;
    @(negedge clk); rd_valid = 0; v = rsp_valid; d = rsp_data;
  endtask

  task automatic unl();
    wr(UA1, 16'h00AA); wr(UA2, 16'h0055);
  endtask

  task automatic busy_len(output int n);
    n = 0;
    while (busy && n < 1000) begin n++; @(negedge clk); end
  endtask

  task automatic check_all(input string tag);
    logic [DW-1:0] d; logic v;
    for (int i = 0; i < WORDS; i++) begin
      rd(AW'(i), d, v);
      chk(v && d == mdl[i], tag, {15'b0, v, d}, {16'h0001, mdl[i]});
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [DW-1:0] d, d2; logic v, v2; int n; logic [AW-1:0] a;
    void'($urandom(32'd4242));
    for (int i = 0; i < WORDS; i++) mdl[i] = '1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(rd_mode == 2'd0 && busy == 0 && wr_ready && rd_ready, "R1 reset state",
        {rd_mode, busy, wr_ready, rd_ready}, 32'h1 << 1 | 32'h1);
    rd(6'd5, d, v);
    chk(v, "R12 response one cycle after request", v, 1);
    chk(d == 16'hFFFF, "R1 array reads all ones", d, 16'hFFFF);

    // R5 and R7: normal four-write program
    for (int k = 0; k < 4; k++) begin
      a = AW'($urandom % WORDS); d2 = DW'($urandom);
      unl(); wr(UA1, 16'h00A0); wr(a, d2);
      busy_len(n);
      chk(n == PROG_CYC, "R7 program busy length", n, PROG_CYC);
      mdl[a] = prog_val(mdl[a], d2);
      rd(a, d, v);
      chk(d == mdl[a], "R5 program result old AND data", d, mdl[a]);
    end
    // R5 bits cannot be set back
    unl(); wr(UA1, 16'h00A0); wr(6'd9, 16'h0F0F); busy_len(n); mdl[9] = prog_val(mdl[9], 16'h0F0F);
    unl(); wr(UA1, 16'h00A0); wr(6'd9, 16'hFFF0); busy_len(n); mdl[9] = prog_val(mdl[9], 16'hFFF0);
    rd(6'd9, d, v);
    chk(d == mdl[9], "R5 second program only clears", d, mdl[9]);

    // R8 status byte during program
    unl(); wr(UA1, 16'h00A0); wr(6'd20, 16'h0011);
    chk(rd_mode == 2'd2 && !wr_ready, "R7 status mode and no write ready", {rd_mode, wr_ready}, 32'h4);
    rd(6'd20, d, v); rd(6'd20, d2, v2);
    chk(d[7] == 1'b1 && d[5:0] == 0 && d[15:8] == 0, "R8 status bit7 complement", d, status_val(16'h0011, d[6]));
    chk(d2[6] != d[6], "R8 status bit6 toggles", d2[6], ~d[6]);
    busy_len(n);
    chk(rd_mode == 2'd0, "R7 mode back to array after program", rd_mode, 0);
    mdl[20] = prog_val(mdl[20], 16'h0011);

    // R2 mismatched unlock
    wr(UA1, 16'h00AA); wr(UA2, 16'h0056); wr(UA1, 16'h00A0); wr(6'd33, 16'h0000);
    chk(!busy && rd_mode == 2'd0, "R2 mismatch no operation", {rd_mode, busy}, 0);
    wr(6'd3, 16'h00AA); wr(UA2, 16'h0055); wr(UA1, 16'h0090);
    chk(rd_mode == 2'd0, "R2 wrong first address keeps array mode", rd_mode, 0);
    check_all("R2 array unchanged after mismatch");

    // R3 and R4 identification
    unl(); wr(UA1, 16'h0090);
    chk(rd_mode == 2'd1, "R3 identify mode", rd_mode, 1);
    rd(6'd4, d, v);
    chk(d == 16'h0037, "R3 maker code", d, 16'h0037);
    rd(6'd7, d, v);
    chk(d == 16'h00C4, "R3 device code", d, 16'h00C4);
    wr(6'd0, 16'h0000);
    chk(rd_mode == 2'd1, "R4 other code stays in identify", rd_mode, 1);
    wr(6'd0, 16'h00F0);
    chk(rd_mode == 2'd0, "R4 reset leaves identify", rd_mode, 0);
    rd(6'd20, d, v);
    chk(d == mdl[20], "R4 array read after reset", d, mdl[20]);

    // R6 fast-program mode
    unl(); wr(UA1, 16'h0020);
    for (int k = 0; k < 8; k++) begin
      a = AW'($urandom % WORDS); d2 = DW'($urandom);
      wr(AW'($urandom), 16'h00A0); wr(a, d2);
      busy_len(n);
      chk(n == PROG_CYC, "R6 two-write program busy", n, PROG_CYC);
      mdl[a] = prog_val(mdl[a], d2);
    end
    check_all("R6 fast-program results");
    wr(6'd1, 16'h00F0);
    wr(6'd1, 16'h00A0); wr(6'd50, 16'h0000);
    chk(!busy, "R4 reset leaves fast-program mode", busy, 0);
    rd(6'd50, d, v);
    chk(d == mdl[50], "R4 no program after reset", d, mdl[50]);

    // R9 multi-sector erase of sectors 1 and 3
    unl(); wr(UA1, 16'h0080); unl(); wr(6'h12, 16'h0030); wr(6'h3C, 16'h0030);
    n = 0;
    while (!busy && n < 50) begin n++; @(negedge clk); end
    busy_len(n);
    chk(n == ERASE_CYC, "R7 erase busy length", n, ERASE_CYC);
    for (int i = 0; i < WORDS; i++) if (i / 16 == 1 || i / 16 == 3) mdl[i] = '1;
    check_all("R9 sector erase contents");

    // R11 deselect during program, deselected write ignored
    unl(); wr(UA1, 16'h00A0); wr(6'd2, 16'h1234);
    chip_en = 0;
    rd(6'd2, d, v);
    chk(!v, "R11 no response while deselected", v, 0);
    n = 2;
    while (busy && n < 1000) begin n++; @(negedge clk); end
    chk(n == PROG_CYC, "R11 operation completes while deselected", n, PROG_CYC);
    mdl[2] = prog_val(mdl[2], 16'h1234);
    wr(UA1, 16'h00AA);
    chip_en = 1;
    wr(UA2, 16'h0055); wr(UA1, 16'h00A0); wr(6'd40, 16'h0000);
    chk(!busy, "R11 deselected write ignored", busy, 0);
    rd(6'd2, d, v);
    chk(d == mdl[2], "R11 program landed", d, mdl[2]);

    // R10 chip erase
    unl(); wr(UA1, 16'h0080); unl(); wr(UA1, 16'h0010);
    busy_len(n);
    chk(n == ERASE_CYC, "R10 chip erase busy", n, ERASE_CYC);
    for (int i = 0; i < WORDS; i++) mdl[i] = '1;
    check_all("R10 chip erase contents");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule